// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the slave-side serial front end of a small byte-addressed nonvolatile memory of 1K x 8. It takes a four-wire SPI bus: clock, chip select, data in and data out. It also takes an active-low pause input. The bus pins are oversampled in the core clock domain. Each command is a stream of bytes, most significant bit first. The first byte is an instruction. The array commands then take a 16-bit address, of which only the low 10 bits are kept. After that come data bytes in either direction.

The engine holds no memory and no protection state itself. It sends requests over a simple parallel interface to a storage sub-block and a status/protection sub-block:
- single-cycle strobes set or clear the write-enable latch;
- a strobe carries a new status byte;
- read and write strobes carry an array address and a data byte.

Read data and status bytes are loaded into a transmit shifter. The output enable stays low except while such bytes are being shifted out.

The state machine has seven states:
- `ST_OPCODE` collects the instruction byte.
- `ST_ADDR` collects the address bytes.
- `ST_ARR_RD` streams array bytes.
- `ST_ARR_WR` accepts array bytes.
- `ST_STAT_RD` streams the status byte.
- `ST_STAT_WR` accepts one status byte.
- `ST_DRAIN` ignores the rest of the select window.

Transitions:
- From `ST_OPCODE`: opcode 0x03 or 0x02 goes to `ST_ADDR`, 0x05 goes to `ST_STAT_RD`, and 0x01 goes to `ST_STAT_WR`. Opcodes 0x06 and 0x04, and any unknown opcode, go to `ST_DRAIN`.
- From `ST_ADDR`, after the last address byte: `ST_ARR_RD` or `ST_ARR_WR`.
- From `ST_STAT_WR`, after its byte: `ST_DRAIN`.
- From every state, chip select going high returns the engine to `ST_OPCODE`.

Top module: `spi_mem_cmd_engine`

## Requirements
- R1: Bits are captured on rising SCK edges only, most significant bit first, and the first rising edge after chip select falls is bit 7 of the instruction. SCK may idle low (mode 0) or high (mode 3).
- R2: Opcode 0x06 gives exactly one `wel_set` pulse and opcode 0x04 gives exactly one `wel_clr` pulse. No two request strobes are ever high in the same cycle.
- R3: Opcode 0x05 shifts `stat_rdata` out on `spi_miso`, repeated byte after byte while chip select stays low.
- R4: Opcode 0x01 gives one `stat_wr_en` pulse, with `stat_wdata` equal to the byte that follows the opcode. Later bytes are ignored.
- R5: Opcode 0x03 followed by a 16-bit address returns the array byte at the low 10 address bits, then bytes from successive addresses for as long as chip select stays low. The address wraps from 0x3FF to 0x000.
- R6: Opcode 0x02 followed by a 16-bit address gives one single-cycle `mem_wr_en` pulse per data byte, at the low 10 address bits and then at successive addresses.
- R7: `spi_miso` changes only after falling SCK edges. Bit 7 of each output byte appears after the first falling edge that follows the rising edge ending the previous byte, and it holds through the next rising edge.
- R8: `spi_miso_oe` is low after reset, while chip select is high, and during the instruction and address bytes. It is high only in a read or status-read data phase.
- R9: While `spi_hold_n` is low, SCK and data transitions are ignored and `spi_miso_oe` is low. After release, the transfer resumes at the exact bit where it paused.
- R10: Chip select going high mid-instruction discards the partial byte with no strobe. The next select window starts a fresh instruction fetch.
- R11: An opcode outside the six listed gives no strobe and no output for the rest of the select window.
- R12: SCK may stop for any length of time, at either level, in the middle of a byte without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_hold_n | input | 1 | Active-low pause |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (low means high impedance) |
| wel_set | output | 1 | Pulse: set the write-enable latch |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |
| stat_rdata | input | 8 | Current status byte from the protection sub-block |
| stat_wr_en | output | 1 | Pulse: write `stat_wdata` to status |
| stat_wdata | output | 8 | Status byte to write |
| mem_addr | output | 10 | Array address for read or write |
| mem_rd_en | output | 1 | Pulse: array read at `mem_addr` |
| mem_rdata | input | 8 | Array data for `mem_addr` (combinational) |
| mem_wr_en | output | 1 | Pulse: write `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Array byte to write |

## Verification
The bench aims at the byte boundaries where the transmit shifter must be reloaded. A design that loaded late would return the previous byte or shift it by one bit. A design that failed to wrap would read 0x400 past the top of the array. It pauses the bus in the middle of a byte, both with the pause pin while toggling SCK and data, and by simply stopping SCK. An engine that did not mask those edges would write or return a corrupted byte, or drive the output while held. It also cuts an instruction short with chip select and sends an unknown opcode. A design that kept the stale bit count or decoded garbage would emit a stray strobe.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam logic [7:0] OP_WEN_SET = 8'h06;
    localparam logic [7:0] OP_WEN_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_ARR_RD  = 8'h03;
    localparam logic [7:0] OP_ARR_WR  = 8'h02;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_ARR_RD,
        ST_ARR_WR,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_DRAIN
    } eng_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
// Brings the asynchronous bus pins into the core clock domain and turns
// SCK transitions into single-cycle edge pulses, masked by select and pause.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic hold_n,
    input  logic mosi,
    output logic sel,
    output logic held,
    output logic rise,
    output logic fall,
    output logic mosi_s
);
    // lane order: [0] sck, [1] hold_n, [2] cs_n, [3] mosi
    localparam logic [3:0] LANE_IDLE = 4'b0110;

    logic [3:0] pipe [STAGES];
    logic [3:0] tip;
    logic       sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= LANE_IDLE;
            sck_q <= 1'b0;
        end else begin
            pipe[0] <= {mosi, cs_n, hold_n, sck};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            sck_q <= pipe[STAGES-1][0];
        end
    end

    assign tip    = pipe[STAGES-1];
    assign sel    = ~tip[2];
    assign held   = ~tip[1];
    assign mosi_s = tip[3];
    assign rise   = sel & ~held &  tip[0] & ~sck_q;
    assign fall   = sel & ~held & ~tip[0] &  sck_q;

endmodule

// File: rtl/spi_rx_byte.sv
// Serial-to-parallel shifter: flags each completed byte for one cycle.
module spi_rx_byte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_in,
    output logic         vld,
    output logic [W-1:0] data
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            vld  <= 1'b0;
            data <= '0;
        end else if (clr) begin
            cnt <= '0;
            vld <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (shift) begin
                data <= {data[W-2:0], bit_in};
                if (cnt == CW'(W - 1)) begin
                    cnt <= '0;
                    vld <= 1'b1;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/spi_tx_byte.sv
// Parallel-to-serial shifter: a loaded byte is armed, and the following
// falling edge presents its top bit; each later falling edge moves one bit on.
module spi_tx_byte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    output logic         so,
    output logic         active
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  out_byte;
    logic [CW-1:0] idx;
    logic          armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_byte <= '0;
            idx      <= '0;
            armed    <= 1'b0;
            so       <= 1'b0;
            active   <= 1'b0;
        end else if (clr) begin
            armed  <= 1'b0;
            so     <= 1'b0;
            active <= 1'b0;
        end else if (load) begin
            out_byte <= load_data;
            armed    <= 1'b1;
        end else if (shift) begin
            if (armed) begin
                so     <= out_byte[W-1];
                idx    <= CW'(W - 2);
                armed  <= 1'b0;
                active <= 1'b1;
            end else begin
                so  <= out_byte[idx];
                idx <= idx - CW'(1);
            end
        end
    end

endmodule

// File: rtl/spi_mem_cmd_engine.sv
module spi_mem_cmd_engine
    import spi_mem_pkg::*;
#(
    parameter int ARR_ADDR_W  = 10,
    parameter int ADDR_BYTES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sck,
    input  logic                  spi_cs_n,
    input  logic                  spi_hold_n,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    output logic                  spi_miso_oe,
    output logic                  wel_set,
    output logic                  wel_clr,
    input  logic [7:0]            stat_rdata,
    output logic                  stat_wr_en,
    output logic [7:0]            stat_wdata,
    output logic [ARR_ADDR_W-1:0] mem_addr,
    output logic                  mem_rd_en,
    input  logic [7:0]            mem_rdata,
    output logic                  mem_wr_en,
    output logic [7:0]            mem_wdata
);
    localparam int BYTE_W = 8;
    localparam int ACW    = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    logic              sel, held, rise, fall, mosi_s;
    logic              byte_vld;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_load, tx_so, tx_active;
    logic [BYTE_W-1:0] tx_data;

    eng_state_t              state_q, state_d;
    logic [ARR_ADDR_W-1:0]   addr_q;
    logic [ARR_ADDR_W-1:0]   addr_sh;
    logic [ARR_ADDR_W-1:0]   addr_next;
    logic [ACW-1:0]          acnt;
    logic                    rd_q;
    logic                    addr_last;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck    (spi_sck),
        .cs_n   (spi_cs_n),
        .hold_n (spi_hold_n),
        .mosi   (spi_mosi),
        .sel    (sel),
        .held   (held),
        .rise   (rise),
        .fall   (fall),
        .mosi_s (mosi_s)
    );

    spi_rx_byte #(.W(BYTE_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (~sel),
        .shift  (rise),
        .bit_in (mosi_s),
        .vld    (byte_vld),
        .data   (rx_byte)
    );

    spi_tx_byte #(.W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (~sel),
        .load      (tx_load),
        .load_data (tx_data),
        .shift     (fall),
        .so        (tx_so),
        .active    (tx_active)
    );

    // address assembled from the bytes so far plus the one just received
    assign addr_next = ARR_ADDR_W'({addr_sh, rx_byte});
    assign addr_last = (acnt == ACW'(ADDR_BYTES - 1));

    // next state
    always_comb begin
        state_d = state_q;
        if (byte_vld) begin
            unique case (state_q)
                ST_OPCODE: begin
                    unique case (rx_byte)
                        OP_ARR_RD, OP_ARR_WR: state_d = ST_ADDR;
                        OP_STAT_RD:           state_d = ST_STAT_RD;
                        OP_STAT_WR:           state_d = ST_STAT_WR;
                        default:              state_d = ST_DRAIN;
                    endcase
                end
                ST_ADDR:    if (addr_last) state_d = rd_q ? ST_ARR_RD : ST_ARR_WR;
                ST_STAT_WR: state_d = ST_DRAIN;
                ST_ARR_RD, ST_ARR_WR, ST_STAT_RD, ST_DRAIN: state_d = state_q;
                default:    state_d = ST_OPCODE;
            endcase
        end
    end

    // state register and transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPCODE;
            addr_q  <= '0;
            addr_sh <= '0;
            acnt    <= '0;
            rd_q    <= 1'b0;
        end else if (!sel) begin
            state_q <= ST_OPCODE;
            acnt    <= '0;
            rd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (byte_vld) begin
                unique case (state_q)
                    ST_OPCODE: begin
                        rd_q <= (rx_byte == OP_ARR_RD);
                        acnt <= '0;
                    end
                    ST_ADDR: begin
                        addr_sh <= addr_next;
                        acnt    <= acnt + ACW'(1);
                        if (addr_last)
                            addr_q <= rd_q ? addr_next + ARR_ADDR_W'(1) : addr_next;
                    end
                    ST_ARR_RD, ST_ARR_WR: addr_q <= addr_q + ARR_ADDR_W'(1);
                    default: ;
                endcase
            end
        end
    end

    // request strobes, transmit loading and pin outputs
    always_comb begin
        wel_set    = 1'b0;
        wel_clr    = 1'b0;
        stat_wr_en = 1'b0;
        mem_rd_en  = 1'b0;
        mem_wr_en  = 1'b0;
        tx_load    = 1'b0;
        tx_data    = mem_rdata;
        mem_addr   = addr_q;
        mem_wdata  = rx_byte;
        stat_wdata = rx_byte;
        if (byte_vld) begin
            unique case (state_q)
                ST_OPCODE: begin
                    if (rx_byte == OP_WEN_SET) wel_set = 1'b1;
                    if (rx_byte == OP_WEN_CLR) wel_clr = 1'b1;
                    if (rx_byte == OP_STAT_RD) begin
                        tx_load = 1'b1;
                        tx_data = stat_rdata;
                    end
                end
                ST_ADDR: begin
                    if (addr_last && rd_q) begin
                        mem_addr  = addr_next;
                        mem_rd_en = 1'b1;
                        tx_load   = 1'b1;
                    end
                end
                ST_ARR_RD: begin
                    mem_rd_en = 1'b1;
                    tx_load   = 1'b1;
                end
                ST_ARR_WR:  mem_wr_en = 1'b1;
                ST_STAT_RD: begin
                    tx_load = 1'b1;
                    tx_data = stat_rdata;
                end
                ST_STAT_WR: stat_wr_en = 1'b1;
                default: ;
            endcase
        end
        spi_miso    = tx_so;
        spi_miso_oe = tx_active & sel & ~held &
                      ((state_q == ST_ARR_RD) || (state_q == ST_STAT_RD));
    end

endmodule

// File: rtl/spi_mem_cmd_chk.sv
module spi_mem_cmd_chk
    import spi_mem_pkg::*;
#(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel,
    input logic          held,
    input eng_state_t    state,
    input logic [AW-1:0] addr,
    input logic          miso_oe,
    input logic          wel_set,
    input logic          wel_clr,
    input logic          stat_wr_en,
    input logic          mem_wr_en,
    input logic          mem_rd_en
);

    // R8: output enabled only in a data-out phase
    p_oe_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> (state == ST_ARR_RD || state == ST_STAT_RD));

    // R9: a pause that has lasted a cycle freezes the transaction context
    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && held && $past(held)) |=> ($stable(state) && $stable(addr)));

    // R10: deselect returns to instruction fetch with the output off
    p_cs_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (state == ST_OPCODE && !miso_oe));

    // R2: request strobes never overlap
    p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wel_set, wel_clr, stat_wr_en, mem_wr_en, mem_rd_en}));

    // R6: one write pulse per byte
    p_wr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en);

endmodule

bind spi_mem_cmd_engine spi_mem_cmd_chk #(.AW(ARR_ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .held       (held),
    .state      (state_q),
    .addr       (addr_q),
    .miso_oe    (spi_miso_oe),
    .wel_set    (wel_set),
    .wel_clr    (wel_clr),
    .stat_wr_en (stat_wr_en),
    .mem_wr_en  (mem_wr_en),
    .mem_rd_en  (mem_rd_en)
);

// File: tb/sim_spi_mem_cmd_engine.sv
module sim_spi_mem_cmd_engine;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_CLKS  = 8;
    localparam int AW         = 10;

    localparam int K_WSET = 0;
    localparam int K_WCLR = 1;
    localparam int K_STAT = 2;
    localparam int K_MEMW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe, wel_set, wel_clr, stat_wr_en, mem_rd_en, mem_wr_en;
    logic [7:0] stat_wdata, mem_wdata, mem_rdata;
    logic [7:0] stat_model = 8'hB2;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_model [1 << AW];

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R2";
    bit mode3 = 1'b0;

    typedef struct {
        int    kind;
        int    addr;
        int    data;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign mem_rdata = mem_model[mem_addr];

    spi_mem_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_hold_n(hold_n), .spi_mosi(mosi), .spi_miso(miso),
        .spi_miso_oe(miso_oe), .wel_set(wel_set), .wel_clr(wel_clr),
        .stat_rdata(stat_model), .stat_wr_en(stat_wr_en), .stat_wdata(stat_wdata),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input int addr, input int data, input string req);
        exp_t e;
        e.kind = kind; e.addr = addr; e.data = data; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic observe(input int kind, input int addr, input int data);
        exp_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, cur_req, "unexpected strobe kind", kind, -1);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == kind, e.req, "strobe kind", kind, e.kind);
            if (kind == K_MEMW || kind == K_STAT)
                chk(e.addr == addr && e.data == data, e.req, "strobe addr/data",
                    (addr << 8) | data, (e.addr << 8) | e.data);
        end
    endtask

    // monitor: scoreboard side
    always @(negedge clk) begin
        if (rst_n) begin
            if (wel_set)    observe(K_WSET, 0, 0);
            if (wel_clr)    observe(K_WCLR, 0, 0);
            if (stat_wr_en) observe(K_STAT, 0, int'(stat_wdata));
            if (mem_wr_en) begin
                observe(K_MEMW, int'(mem_addr), int'(mem_wdata));
                mem_model[mem_addr] = mem_wdata;
            end
        end
    end

    task automatic half();
        repeat (HALF_CLKS) @(negedge clk);
    endtask

    task automatic cs_begin();
        sck = mode3; mosi = 1'b0;
        half();
        cs_n = 1'b0;
        half();
    endtask

    task automatic cs_end();
        if (!mode3) sck = 1'b0;
        half();
        cs_n = 1'b1;
        half(); half();
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at,
                        input int pause_at, output logic [7:0] rx, output logic oe_any,
                        output logic oe_all, output logic stable_ok, output logic hold_quiet);
        rx = 8'h00; oe_any = 1'b0; oe_all = 1'b1; stable_ok = 1'b1; hold_quiet = 1'b1;
        for (int b = 7; b > 7 - nbits; b--) begin
            sck = 1'b0; mosi = tx[b];
            half();
            if (b == hold_at) begin
                hold_n = 1'b0;
                half();
                if (miso_oe) hold_quiet = 1'b0;
                for (int k = 0; k < 2; k++) begin
                    sck = 1'b1; mosi = ~tx[b];
                    half();
                    if (miso_oe) hold_quiet = 1'b0;
                    sck = 1'b0; mosi = tx[b];
                    half();
                end
                hold_n = 1'b1;
                half();
            end
            rx[b] = miso;
            oe_any |= miso_oe;
            oe_all &= miso_oe;
            sck = 1'b1;
            half();
            if (b == pause_at) repeat (400) @(negedge clk);
            if (miso !== rx[b]) stable_ok = 1'b0;
            oe_any |= miso_oe;
        end
    endtask

    logic [7:0] r;
    logic oa, oall, st, hq;

    task automatic put(input logic [7:0] b, input string req);
        xfer(b, 8, -1, -1, r, oa, oall, st, hq);
        chk(!oa, req, "SO enabled outside a data-out phase", int'(oa), 0);
    endtask

    task automatic put_hold(input logic [7:0] b, input int hold_at, input string req);
        xfer(b, 8, hold_at, -1, r, oa, oall, st, hq);
        chk(!oa, req, "SO enabled during write byte with pause", int'(oa), 0);
    endtask

    task automatic get(input logic [7:0] exp, input string req, input int hold_at,
                       input int pause_at);
        xfer(8'h00, 8, hold_at, pause_at, r, oa, oall, st, hq);
        chk(r == exp, req, "read byte", int'(r), int'(exp));
        chk(oall && st, "R7", "SO driven and held across rising edges",
            int'({oall, st}), 3);
        if (hold_at >= 0) chk(hq, "R9", "SO disabled while held", int'(hq), 1);
    endtask

    task automatic drained(input string req);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, req, "scoreboard items left", exp_q.size(), 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++)
            mem_model[i] = 8'((i * 7 + 3) ^ (i >> 3));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(miso_oe == 1'b0, "R8", "SO enable after reset", int'(miso_oe), 0);

        // R2: latch set, mode 0
        mode3 = 1'b0; cur_req = "R2";
        push(K_WSET, 0, 0, "R2");
        cs_begin(); put(8'h06, "R8"); cs_end();
        drained("R2");

        // R1 / R2: latch clear in mode 3
        mode3 = 1'b1; cur_req = "R1";
        push(K_WCLR, 0, 0, "R1");
        cs_begin(); put(8'h04, "R8"); cs_end();
        drained("R1");

        // R4: status write, trailing byte ignored
        mode3 = 1'b0; cur_req = "R4";
        push(K_STAT, 0, 8'h8C, "R4");
        cs_begin(); put(8'h01, "R8"); put(8'h8C, "R4"); put(8'h33, "R4"); cs_end();
        drained("R4");

        // R3: status read repeats
        cur_req = "R3";
        cs_begin(); put(8'h05, "R8");
        get(8'hB2, "R3", -1, -1); get(8'hB2, "R3", -1, -1);
        cs_end();

        // R6: array write with high address bits discarded, mode 3
        mode3 = 1'b1; cur_req = "R6";
        push(K_MEMW, 10'h03E, 8'h11, "R6");
        push(K_MEMW, 10'h03F, 8'h22, "R6");
        push(K_MEMW, 10'h040, 8'h33, "R6");
        cs_begin(); put(8'h02, "R8"); put(8'hFC, "R8"); put(8'h3E, "R8");
        put(8'h11, "R6"); put(8'h22, "R6"); put(8'h33, "R6"); cs_end();
        drained("R6");

        // R5: read back across the written bytes, mode 0
        mode3 = 1'b0; cur_req = "R5";
        cs_begin(); put(8'h03, "R8"); put(8'h00, "R8"); put(8'h3E, "R8");
        get(8'h11, "R5", -1, -1); get(8'h22, "R5", -1, -1); get(8'h33, "R5", -1, -1);
        cs_end();

        // R5: wrap at top of array, mode 3
        mode3 = 1'b1;
        cs_begin(); put(8'h03, "R8"); put(8'h83, "R8"); put(8'hFE, "R8");
        get(mem_model[10'h3FE], "R5", -1, -1);
        get(mem_model[10'h3FF], "R5", -1, -1);
        get(mem_model[10'h000], "R5", -1, -1);
        cs_end();

        // R9: pause in the middle of a write byte with toggling pins
        mode3 = 1'b0; cur_req = "R9";
        push(K_MEMW, 10'h100, 8'h5A, "R9");
        cs_begin(); put(8'h02, "R8"); put(8'h01, "R8"); put(8'h00, "R8");
        put_hold(8'h5A, 4, "R9"); cs_end();
        drained("R9");

        // R9 / R12: pause pin and a stopped clock inside a read byte
        cs_begin(); put(8'h03, "R8"); put(8'h01, "R8"); put(8'h00, "R8");
        get(8'h5A, "R9", 3, -1);
        get(mem_model[10'h101], "R12", -1, 5);
        cs_end();

        // R10: deselect after four instruction bits, then a clean command
        cur_req = "R10";
        cs_begin();
        xfer(8'h06, 4, -1, -1, r, oa, oall, st, hq);
        cs_end();
        drained("R10");
        push(K_WSET, 0, 0, "R10");
        cs_begin(); put(8'h06, "R10"); cs_end();
        drained("R10");

        // R11: unknown opcode swallows the rest of the window
        cur_req = "R11";
        cs_begin(); put(8'hA5, "R11"); put(8'h06, "R11"); put(8'h03, "R11"); cs_end();
        drained("R11");

        finish_run();
    end

endmodule